// File: doc/BRIEF.md
# Bus Target Configuration Register Space

This block holds the 256-byte configuration register space of a single-function peripheral that sits on a PCI-style bus. Software reaches it one 32-bit doubleword at a time through a simple register port. The port has a strobe, a read/write select, a 6-bit doubleword index, a write bus with per-byte enables and a registered read bus. Read-only identity words tell software which vendor, which device and which class of function it is talking to. Software then sizes and programs up to six base address registers, and turns on decoding through the command word.

The lowest 64 bytes (doublewords 0 to 15) form a fixed header. Doublewords 16 to 63 are plain read/write storage. The base address registers also drive live address-match outputs. The target's bus logic presents an incoming address and its space (I/O or memory), and the block reports which base registers claim it. A register only claims an address when the space enable for its kind is set in the command word.

Top module: `cfg_space`

## Requirements
- R1: Doubleword 0 reads as the device ID in bits 31:16 and the vendor ID in bits 15:0, and writes to it change nothing.
- R2: Doubleword 2 reads as the 24-bit class code in bits 31:8 and the revision in bits 7:0, and writes to it change nothing.
- R3: A read strobe loads the read bus on the next clock edge. The read bus holds its value on every cycle without a read strobe, including write cycles.
- R4: Reset clears the command word, every base register and the read bus. After reset no match output is high.
- R5: Doubleword 1 holds the command word. Bit 0 is the I/O space enable, bit 1 the memory space enable and bit 2 the bus-master enable, and these three bits are writable. Every other bit, including the upper status half, reads zero.
- R6: Base register n (0 ≤ n < NUM_BAR) sits at doubleword 4+n. Its address bits below its configured size read zero, so writing all ones and reading back gives the negated size. Base register slots at or above NUM_BAR read zero.
- R7: A write changes only the byte lanes whose enable is set (bit k of the enables covers data bits 8k+7:8k).
- R8: Doublewords 16 to 63 store and return any value written. The reserved header doublewords 3 and 10 to 15 read zero.
- R9: Match output n is high when the access space matches the kind of base register n (I/O or memory), the enable for that space is set, and the address bits at and above the register's size equal the register.
- R10: With the I/O enable clear, no I/O-kind register matches. With the memory enable clear, no memory-kind register matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 selects a write, 0 a read |
| acc_idx | input | 6 | Doubleword index 0 to 63 |
| acc_wdata | input | 32 | Write data |
| acc_be | input | 4 | Byte-lane write enables |
| acc_rdata | output | 32 | Registered read data |
| bus_addr | input | 32 | Address of the bus access to decode |
| bus_is_io | input | 1 | 1 when the bus access is to I/O space, 0 for memory |
| bar_hit | output | 6 | Per-base-register address match |

## Verification
On every cycle the assertions check the gating of match outputs by the space enables, that the read bus holds between read strobes, and what reads of the identity, reserved and first base register words return. Some behaviour can only be shown by the bench's scenarios. That covers sizing by writing all ones, partial byte-lane merges, the upper storage area, and matches and misses at chosen addresses after software has placed the registers. It also covers reset in the middle of a run.

// File: rtl/cfg_space.sv
module cfg_space #(
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
  parameter logic [23:0] CLASS_CODE = 24'h078000,
  parameter logic [7:0]  REV_ID     = 8'h05,
  parameter int          NUM_BAR    = 6,
  parameter logic [47:0] BAR_LOG2   = {8'd24, 8'd20, 8'd4, 8'd16, 8'd8, 8'd12},
  parameter logic [5:0]  BAR_IO     = 6'b001010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_wr,
  input  logic [5:0]  acc_idx,
  input  logic [31:0] acc_wdata,
  input  logic [3:0]  acc_be,
  output logic [31:0] acc_rdata,
  input  logic [31:0] bus_addr,
  input  logic        bus_is_io,
  output logic [5:0]  bar_hit
);
  localparam int DW_TOTAL = 64;
  localparam int HDR_DW   = 16;
  localparam int EXT_DW   = DW_TOTAL - HDR_DW;
  localparam int BAR_BASE = 4;
  localparam int BAR_SLOT = 6;

  logic        wr_en, rd_en;
  logic [2:0]  cmd_q;
  logic [31:0] bar_val [BAR_SLOT];
  logic [31:0] ext_q   [EXT_DW];
  logic [31:0] rd_mux;
  logic [5:0]  ext_idx;

  assign wr_en   = acc_en & acc_wr;
  assign rd_en   = acc_en & ~acc_wr;
  assign ext_idx = acc_idx - 6'(HDR_DW);

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      cmd_q <= '0;
    else if (wr_en && acc_idx == 6'd1 && acc_be[0])
      cmd_q <= acc_wdata[2:0];

  for (genvar g = 0; g < BAR_SLOT; g++) begin : g_bar
    if (g < NUM_BAR) begin : g_on
      localparam logic [31:0] MASK = ~((32'd1 << BAR_LOG2[8*g +: 8]) - 32'd1);
      logic [31:0] q;
      logic        space_ok;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          q <= '0;
        else if (wr_en && acc_idx == 6'(BAR_BASE + g))
          q <= lane_merge(q, acc_wdata, acc_be) & MASK;
      assign space_ok   = BAR_IO[g] ? (cmd_q[0] & bus_is_io) : (cmd_q[1] & ~bus_is_io);
      assign bar_val[g] = q;
      assign bar_hit[g] = space_ok & ((bus_addr & MASK) == q);
    end else begin : g_off
      assign bar_val[g] = '0;
      assign bar_hit[g] = 1'b0;
    end
  end

  always_ff @(posedge clk)
    if (wr_en && acc_idx >= 6'(HDR_DW))
      for (int b = 0; b < 4; b++)
        if (acc_be[b])
          ext_q[ext_idx][8*b +: 8] <= acc_wdata[8*b +: 8];

  always_comb begin
    rd_mux = '0;
    if (acc_idx >= 6'(HDR_DW))
      rd_mux = ext_q[ext_idx];
    else if (acc_idx >= 6'(BAR_BASE) && acc_idx < 6'(BAR_BASE + BAR_SLOT))
      rd_mux = bar_val[3'(acc_idx - 6'(BAR_BASE))];
    else
      case (acc_idx)
        6'd0:    rd_mux = {DEVICE_ID, VENDOR_ID};
        6'd1:    rd_mux = {29'd0, cmd_q};
        6'd2:    rd_mux = {CLASS_CODE, REV_ID};
        default: rd_mux = '0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      acc_rdata <= '0;
    else if (rd_en)
      acc_rdata <= rd_mux;
endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
  parameter logic [23:0] CLASS_CODE = 24'h078000,
  parameter logic [7:0]  REV_ID     = 8'h05,
  parameter logic [47:0] BAR_LOG2   = {8'd24, 8'd20, 8'd4, 8'd16, 8'd8, 8'd12},
  parameter logic [5:0]  BAR_IO     = 6'b001010
) (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_en,
  input logic        acc_wr,
  input logic [5:0]  acc_idx,
  input logic [31:0] acc_rdata,
  input logic [2:0]  cmd_q,
  input logic [5:0]  bar_hit
);
  localparam logic [31:0] LOW0 = (32'd1 << BAR_LOG2[7:0]) - 32'd1;

  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_idx == 6'd0) |=> acc_rdata == {DEVICE_ID, VENDOR_ID}); // R1
  AST_CLASS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_idx == 6'd2) |=> acc_rdata == {CLASS_CODE, REV_ID}); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_wr) |=> $stable(acc_rdata)); // R3
  AST_CMD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_idx == 6'd1) |=> acc_rdata[31:3] == '0); // R5
  AST_BAR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_idx == 6'd4) |=> (acc_rdata & LOW0) == '0); // R6
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_idx == 6'd3) |=> acc_rdata == '0); // R8
  AST_IO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[0] |-> (bar_hit & BAR_IO) == '0); // R10
  AST_MEM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[1] |-> (bar_hit & ~BAR_IO) == '0); // R10
endmodule

bind cfg_space cfg_space_chk #(
  .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CLASS_CODE(CLASS_CODE),
  .REV_ID(REV_ID), .BAR_LOG2(BAR_LOG2), .BAR_IO(BAR_IO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_idx(acc_idx),
  .acc_rdata(acc_rdata), .cmd_q(cmd_q), .bar_hit(bar_hit)
);

// File: tb/tb_cfg_space.sv
`timescale 1ns/1ps
module tb_cfg_space;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [5:0]  acc_idx = '0;
  logic [31:0] acc_wdata = '0;
  logic [3:0]  acc_be = '0;
  logic [31:0] acc_rdata;
  logic [31:0] bus_addr = '0;
  logic        bus_is_io = 1'b0;
  logic [5:0]  bar_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_space dut (.*);

  // {req[78:75], wr[74], idx[73:68], wdata[67:36], be[35:32], expected[31:0]}
  localparam int NV = 19;
  localparam logic [78:0] VEC [NV] = '{
    {4'd1, 1'b0, 6'd0,  32'h0,        4'hF, 32'h3C4D1A2B}, // R1
    {4'd1, 1'b1, 6'd0,  32'hFFFFFFFF, 4'hF, 32'h3C4D1A2B}, // R1
    {4'd2, 1'b1, 6'd2,  32'h00000000, 4'hF, 32'h07800005}, // R2
    {4'd5, 1'b1, 6'd1,  32'hFFFFFFFF, 4'hF, 32'h00000007}, // R5
    {4'd5, 1'b1, 6'd1,  32'h00000000, 4'hF, 32'h00000000}, // R5
    {4'd6, 1'b1, 6'd4,  32'hFFFFFFFF, 4'hF, 32'hFFFFF000}, // R6
    {4'd6, 1'b1, 6'd5,  32'hFFFFFFFF, 4'hF, 32'hFFFFFF00}, // R6
    {4'd6, 1'b1, 6'd7,  32'hFFFFFFFF, 4'hF, 32'hFFFFFFF0}, // R6
    {4'd6, 1'b1, 6'd9,  32'hFFFFFFFF, 4'hF, 32'hFF000000}, // R6
    {4'd7, 1'b1, 6'd4,  32'h12345678, 4'h3, 32'hFFFF5000}, // R7
    {4'd7, 1'b1, 6'd4,  32'hABCDEF01, 4'h8, 32'hABFF5000}, // R7
    {4'd8, 1'b1, 6'd20, 32'hDEADBEEF, 4'hF, 32'hDEADBEEF}, // R8
    {4'd7, 1'b1, 6'd20, 32'h00112233, 4'h5, 32'hDE11BE33}, // R7
    {4'd8, 1'b1, 6'd63, 32'hCAFEF00D, 4'hF, 32'hCAFEF00D}, // R8
    {4'd8, 1'b1, 6'd16, 32'h01234567, 4'hF, 32'h01234567}, // R8
    {4'd8, 1'b1, 6'd3,  32'hFFFFFFFF, 4'hF, 32'h00000000}, // R8
    {4'd8, 1'b1, 6'd12, 32'hFFFFFFFF, 4'hF, 32'h00000000}, // R8
    {4'd8, 1'b0, 6'd20, 32'h0,        4'hF, 32'hDE11BE33}, // R8
    {4'd5, 1'b1, 6'd1,  32'h12345678, 4'h1, 32'h00000000}  // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] idx, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_idx = idx; acc_wdata = d; acc_be = be;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] idx);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_idx = idx;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input logic io);
    @(negedge clk);
    bus_addr = a; bus_is_io = io;
    #1;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R4 rdata", acc_rdata, 32'h0);
    rst_n = 1'b1;
    rd(6'd1); check("R4 command", acc_rdata, 32'h0);
    for (int i = 4; i < 10; i++) begin
      rd(6'(i)); check("R4 bar", acc_rdata, 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][78:75], i);
      if (VEC[i][74]) wr(VEC[i][73:68], VEC[i][67:36], VEC[i][35:32]);
      rd(VEC[i][73:68]);
      check(tag, acc_rdata, VEC[i][31:0]);
    end

    // R3: read bus holds across idle and write cycles
    rd(6'd0);
    wr(6'd20, 32'h55555555, 4'hF);
    repeat (2) @(negedge clk);
    check("R3 hold", acc_rdata, 32'h3C4D1A2B);

    // R9 / R10 decode
    wr(6'd4, 32'h00010000, 4'hF);
    wr(6'd5, 32'h00000200, 4'hF);
    wr(6'd8, 32'h80000000, 4'hF);
    wr(6'd1, 32'h0, 4'hF);
    probe(32'h00010ABC, 1'b0); check("R10 mem off", {26'd0, bar_hit}, 32'h0);
    wr(6'd1, 32'h2, 4'hF);
    probe(32'h00010ABC, 1'b0); check("R9 mem hit", {26'd0, bar_hit}, 32'h1);
    probe(32'h00011000, 1'b0); check("R9 mem miss", {26'd0, bar_hit}, 32'h0);
    probe(32'h00000210, 1'b1); check("R10 io off", {26'd0, bar_hit}, 32'h0);
    wr(6'd1, 32'h3, 4'hF);
    probe(32'h00000210, 1'b1); check("R9 io hit", {26'd0, bar_hit}, 32'h2);
    probe(32'h00010ABC, 1'b1); check("R9 space mismatch", {26'd0, bar_hit}, 32'h0);
    probe(32'h800FFFFC, 1'b0); check("R9 bar4 hit", {26'd0, bar_hit}, 32'h10);

    // R4: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R4 rdata mid", acc_rdata, 32'h0);
    check("R4 hit mid", {26'd0, bar_hit}, 32'h0);
    rst_n = 1'b1;
    rd(6'd4); check("R4 bar0 mid", acc_rdata, 32'h0);
    rd(6'd1); check("R4 cmd mid", acc_rdata, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule